// File: doc/BRIEF.md
# Complement-checked serial programming receiver

This block sits in a small device and receives its configuration over two pins: a clock line driven by an external programmer, and a shared data line. The programmer opens a session with a timed pattern. It holds the clock line high for a long setup period, then raises the data line while the two spare button inputs stay low. It then clocks in twelve 16-bit words. Each word is followed by its bitwise inverse. The receiver accepts a word only when the two halves agree. A modelled non-volatile write delay follows each accepted word, and after it the receiver answers with an acknowledge level on the data line.

When all twelve words are in, the programmer may read the 192-bit image back once, one bit per falling clock edge. After that single pass, or after any attempt to begin a new session during it, the receiver locks. It ignores the pins until the power-on reset (`rst`) is asserted again. A failed complement check sets a sticky error flag and abandons the session. A readback is then impossible until a complete program cycle has been run. Both pins are synchronised to the system clock inside the block, and the edges on them are detected there too.

Top module: `prg_rx`

## Requirements
- R1: While `rst` is high, and on the cycle after it, `dat_oe` and `err_flag` are 0 and `cfg_image` is all zeros. This also clears the readback lockout.
- R2: A session opens only when the synchronised clock line has been high for at least `HOLD_CYC` system cycles and the data line then rises. After a shorter hold, a following word/complement pair produces no acknowledge and is not stored.
- R3: A session does not open if either bit of `btn_in` is 1 when the data line rises.
- R4: Data is sampled on rising edges of the clock line, least significant bit first. The first 16 bits form the word and the next 16 bits form its complement.
- R5: If the complement half is not the exact inverse of the word half, nothing is stored and no acknowledge is driven. `err_flag` goes to 1 and stays there until reset, and the receiver returns to waiting for a new session.
- R6: Word k of an accepted pair appears in `cfg_image[16k+15:16k]` after `WRITE_CYC` cycles. In the same cycle the receiver drives `dat_oe`=1 and `dat_out`=1 as the acknowledge, and it releases both on the next rising clock-line edge.
- R7: Clock-line edges that arrive during the write delay are ignored. They neither shift data nor shorten the delay.
- R8: Accepting word 0 of a session clears words 1 to 11 of the image (bulk write).
- R9: After the twelfth acknowledge ends, each falling clock-line edge drives the next image bit on `dat_out` with `dat_oe`=1, starting at `cfg_image[0]`. The image is frozen during this pass. The falling edge after bit 191 releases the line.
- R10: After the readback pass the receiver is locked. Session patterns and clock edges never drive the data line or change the image until reset.
- R11: Readback is refused unless a program cycle has just completed. After an abandoned session, falling clock edges do not drive the data line.
- R12: `dat_oe` is 1 only during an acknowledge or the readback pass.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset; also clears the lockout |
| ck_line | input | 1 | Asynchronous programming clock line |
| dat_in | input | 1 | Asynchronous data line as seen at the pin |
| btn_in | input | 2 | The two spare button inputs; must be low to open a session |
| dat_out | output | 1 | Value driven onto the data line |
| dat_oe | output | 1 | Output enable for the data line |
| err_flag | output | 1 | Sticky complement-mismatch flag |
| cfg_image | output | 192 | Twelve stored configuration words, word k at bits 16k+15:16k |

## Verification
Several properties are checked on every cycle. The error flag never falls outside reset, and the data line is enabled only in the acknowledge or readback phases. The acknowledge level is high, and a write wait can end only in an acknowledge. The image is frozen during readback and in the locked state, and the locked state is terminal. Other behaviour shows only in the bench's scenarios. These are the setup-time and button qualifiers on session entry, least-significant-first word assembly and the bulk clear on word 0. They also cover the bit-by-bit readback order, the refusal of readback after an abandoned session, and edges ignored during the write delay.

// File: rtl/prg_pkg.sv
package prg_pkg;

    localparam int WORD_W = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_WAIT,
        ST_ACK,
        ST_VERIFY,
        ST_LOCK
    } rx_state_e;

    typedef struct packed {
        logic lvl;
        logic rise;
        logic fall;
    } line_ev_t;

    function automatic logic pair_ok(input logic [2*WORD_W-1:0] pair);
        return pair[2*WORD_W-1:WORD_W] == ~pair[WORD_W-1:0];
    endfunction

endpackage

// File: rtl/prg_line_sync.sv
module prg_line_sync #(
    parameter int STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               din,
    output prg_pkg::line_ev_t  ev
);
    logic [STAGES-1:0] chain;
    logic              last;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
            last  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], din};
            last  <= chain[STAGES-1];
        end
    end

    assign ev.lvl  = chain[STAGES-1];
    assign ev.rise = chain[STAGES-1] & ~last;
    assign ev.fall = ~chain[STAGES-1] & last;
endmodule

// File: rtl/prg_entry_det.sv
module prg_entry_det #(
    parameter int HOLD_CYC = 1_800_000
) (
    input  logic               clk,
    input  logic               rst,
    input  prg_pkg::line_ev_t  ck_ev,
    input  prg_pkg::line_ev_t  dat_ev,
    input  logic               btn_quiet,
    output logic               enter
);
    localparam int CW = $clog2(HOLD_CYC + 1);

    logic [CW-1:0] high_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            high_cnt <= '0;
        end else if (!ck_ev.lvl) begin
            high_cnt <= '0;
        end else if (high_cnt != CW'(HOLD_CYC)) begin
            high_cnt <= high_cnt + 1'b1;
        end
    end

    assign enter = ck_ev.lvl && (high_cnt == CW'(HOLD_CYC)) && dat_ev.rise && btn_quiet;
endmodule

// File: rtl/prg_wr_timer.sv
module prg_wr_timer #(
    parameter int WRITE_CYC = 6_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic done
);
    localparam int CW = $clog2(WRITE_CYC + 1);

    logic          busy;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= '0;
        end else if (busy) begin
            if (cnt == CW'(WRITE_CYC - 1)) begin
                busy <= 1'b0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign done = busy && (cnt == CW'(WRITE_CYC - 1));
endmodule

// File: rtl/prg_cfg_store.sv
module prg_cfg_store #(
    parameter int WORD_W  = 16,
    parameter int N_WORDS = 12,
    parameter int IDX_W   = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      we,
    input  logic                      bulk,
    input  logic [IDX_W-1:0]          idx,
    input  logic [WORD_W-1:0]         wdata,
    output logic [N_WORDS*WORD_W-1:0] image
);
    for (genvar k = 0; k < N_WORDS; k++) begin : g_word
        logic [WORD_W-1:0] word_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                word_q <= '0;
            end else if (we && (idx == IDX_W'(k))) begin
                word_q <= wdata;
            end else if (we && bulk) begin
                word_q <= '0;
            end
        end

        assign image[k*WORD_W +: WORD_W] = word_q;
    end
endmodule

// File: rtl/prg_rx.sv
module prg_rx #(
    parameter int N_WORDS     = 12,
    parameter int HOLD_CYC    = 1_800_000,
    parameter int WRITE_CYC   = 6_000_000,
    parameter int SYNC_STAGES = 2
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               ck_line,
    input  logic                               dat_in,
    input  logic [1:0]                         btn_in,
    output logic                               dat_out,
    output logic                               dat_oe,
    output logic                               err_flag,
    output logic [N_WORDS*prg_pkg::WORD_W-1:0] cfg_image
);
    import prg_pkg::*;

    localparam int W      = WORD_W;
    localparam int PAIR_W = 2 * W;
    localparam int BC_W   = $clog2(PAIR_W);
    localparam int IDX_W  = (N_WORDS > 1) ? $clog2(N_WORDS) : 1;
    localparam int IMG_W  = N_WORDS * W;
    localparam int RD_W   = $clog2(IMG_W + 1);

    logic [1:0] raw_lines;
    line_ev_t   line_ev [2];
    line_ev_t   ck_ev;
    line_ev_t   dat_ev;

    assign raw_lines = {dat_in, ck_line};

    for (genvar g = 0; g < 2; g++) begin : g_sync
        prg_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk (clk),
            .rst (rst),
            .din (raw_lines[g]),
            .ev  (line_ev[g])
        );
    end

    assign ck_ev  = line_ev[0];
    assign dat_ev = line_ev[1];

    logic enter;

    prg_entry_det #(.HOLD_CYC(HOLD_CYC)) u_entry (
        .clk       (clk),
        .rst       (rst),
        .ck_ev     (ck_ev),
        .dat_ev    (dat_ev),
        .btn_quiet (btn_in == 2'b00),
        .enter     (enter)
    );

    rx_state_e         state;
    logic [BC_W-1:0]   bit_cnt;
    logic [PAIR_W-1:0] shreg;
    logic [PAIR_W-1:0] next_pair;
    logic [IDX_W-1:0]  word_idx;
    logic [RD_W-1:0]   rd_idx;
    logic [W-1:0]      pend_word;
    logic              last_bit;
    logic              wr_start;
    logic              wr_done;
    logic              st_we;

    assign next_pair = {dat_ev.lvl, shreg[PAIR_W-1:1]};
    assign last_bit  = (bit_cnt == BC_W'(PAIR_W - 1));
    assign wr_start  = (state == ST_SHIFT) && ck_ev.rise && last_bit && pair_ok(next_pair);
    assign st_we     = (state == ST_WAIT) && wr_done;

    prg_wr_timer #(.WRITE_CYC(WRITE_CYC)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .start (wr_start),
        .done  (wr_done)
    );

    prg_cfg_store #(.WORD_W(W), .N_WORDS(N_WORDS), .IDX_W(IDX_W)) u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (st_we),
        .bulk  (word_idx == '0),
        .idx   (word_idx),
        .wdata (pend_word),
        .image (cfg_image)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            bit_cnt   <= '0;
            shreg     <= '0;
            word_idx  <= '0;
            rd_idx    <= '0;
            pend_word <= '0;
            err_flag  <= 1'b0;
            dat_out   <= 1'b0;
            dat_oe    <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (enter) begin
                        state    <= ST_SHIFT;
                        bit_cnt  <= '0;
                        word_idx <= '0;
                    end
                end
                ST_SHIFT: begin
                    if (ck_ev.rise) begin
                        shreg <= next_pair;
                        if (last_bit) begin
                            bit_cnt <= '0;
                            if (pair_ok(next_pair)) begin
                                pend_word <= next_pair[W-1:0];
                                state     <= ST_WAIT;
                            end else begin
                                err_flag <= 1'b1;
                                state    <= ST_IDLE;
                            end
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                end
                ST_WAIT: begin
                    if (wr_done) begin
                        state   <= ST_ACK;
                        dat_oe  <= 1'b1;
                        dat_out <= 1'b1;
                    end
                end
                ST_ACK: begin
                    if (ck_ev.rise) begin
                        dat_oe  <= 1'b0;
                        dat_out <= 1'b0;
                        if (word_idx == IDX_W'(N_WORDS - 1)) begin
                            state  <= ST_VERIFY;
                            rd_idx <= '0;
                        end else begin
                            word_idx <= word_idx + 1'b1;
                            state    <= ST_SHIFT;
                        end
                    end
                end
                ST_VERIFY: begin
                    if (enter) begin
                        state   <= ST_LOCK;
                        dat_oe  <= 1'b0;
                        dat_out <= 1'b0;
                    end else if (ck_ev.fall) begin
                        if (rd_idx == RD_W'(IMG_W)) begin
                            state   <= ST_LOCK;
                            dat_oe  <= 1'b0;
                            dat_out <= 1'b0;
                        end else begin
                            dat_oe  <= 1'b1;
                            dat_out <= cfg_image[rd_idx];
                            rd_idx  <= rd_idx + 1'b1;
                        end
                    end
                end
                ST_LOCK: begin
                    state <= ST_LOCK;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/prg_rx_chk.sv
module prg_rx_chk #(
    parameter int IMG_W = 192
) (
    input logic                clk,
    input logic                rst,
    input prg_pkg::rx_state_e  state,
    input logic                dat_oe,
    input logic                dat_out,
    input logic                err_flag,
    input logic [IMG_W-1:0]    cfg_image
);
    import prg_pkg::*;

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!dat_oe && !err_flag && (cfg_image == '0)));

    p_err_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        err_flag |=> err_flag);

    p_ack_level_r6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ACK && dat_oe) |-> dat_out);

    p_wait_exit_r7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT) |=> (state == ST_WAIT || state == ST_ACK));

    p_verify_frozen_r9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_VERIFY) |=> $stable(cfg_image));

    p_lock_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LOCK) |=> (state == ST_LOCK && $stable(cfg_image) && !dat_oe));

    p_oe_phase_r12: assert property (@(posedge clk) disable iff (rst)
        dat_oe |-> (state == ST_ACK || state == ST_VERIFY));
endmodule

bind prg_rx prg_rx_chk #(.IMG_W(IMG_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .state     (state),
    .dat_oe    (dat_oe),
    .dat_out   (dat_out),
    .err_flag  (err_flag),
    .cfg_image (cfg_image)
);

// File: tb/prg_rx_test.sv
`timescale 1ns/1ps
module prg_rx_test;
    import prg_pkg::*;

    localparam int NW   = 12;
    localparam int W    = WORD_W;
    localparam int IMG  = NW * W;
    localparam int HOLD = 40;
    localparam int WR   = 30;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ck_line = 1'b0;
    logic dat_in = 1'b0;
    logic [1:0] btn_in = 2'b00;
    logic dat_out, dat_oe, err_flag;
    logic [IMG-1:0] cfg_image;

    int vectors = 0;
    int miscompares = 0;
    int cyc_cnt = 0;
    logic [IMG-1:0] exp_img = '0;
    logic exp_err = 1'b0;
    logic allow_oe = 1'b0;

    prg_rx #(.N_WORDS(NW), .HOLD_CYC(HOLD), .WRITE_CYC(WR), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst(rst), .ck_line(ck_line), .dat_in(dat_in), .btn_in(btn_in),
        .dat_out(dat_out), .dat_oe(dat_oe), .err_flag(err_flag), .cfg_image(cfg_image)
    );

    always #2.5 clk = ~clk;

    // per-cycle model comparison: data line enabled only in permitted windows (R12)
    always @(negedge clk) begin
        if (!rst) begin
            vectors++;
            if (dat_oe && !allow_oe) begin
                miscompares++;
                $display("FAIL R12 line enabled outside window: actual %b expected 0", dat_oe);
            end
        end
    end

    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt == 100000) begin
            miscompares++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc_cnt);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input string what,
                         input logic [IMG-1:0] act, input logic [IMG-1:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic enter_mode(input int hold);
        ck_line = 1'b1;
        dat_in  = 1'b0;
        wait_cyc(hold);
        dat_in = 1'b1;
        wait_cyc(10);
        ck_line = 1'b0;
        wait_cyc(10);
    endtask

    task automatic put_bit(input logic b);
        dat_in = b;
        wait_cyc(5);
        ck_line = 1'b1;
        wait_cyc(10);
        ck_line = 1'b0;
        wait_cyc(5);
    endtask

    task automatic put_pair(input logic [W-1:0] w, input logic [W-1:0] c);
        for (int i = 0; i < W; i++) put_bit(w[i]);
        for (int i = 0; i < W; i++) put_bit(c[i]);
    endtask

    task automatic expect_ack(input string req);
        allow_oe = 1'b1;
        wait_cyc(WR + 20);
        check(req, "ack enable", dat_oe, 1);
        check(req, "ack level", dat_out, 1);
        ck_line = 1'b1;
        wait_cyc(10);
        check(req, "ack release", dat_oe, 0);
        allow_oe = 1'b0;
    endtask

    task automatic lower_ck();
        ck_line = 1'b0;
        wait_cyc(5);
    endtask

    task automatic expect_no_ack(input string req);
        wait_cyc(WR + 20);
        check(req, "no ack", dat_oe, 0);
    endtask

    task automatic falls_no_drive(input string req);
        for (int i = 0; i < 4; i++) begin
            ck_line = 1'b1;
            wait_cyc(8);
            ck_line = 1'b0;
            wait_cyc(8);
            check(req, "line after fall", dat_oe, 0);
        end
    endtask

    task automatic program_word(input int k, input logic [W-1:0] w, input bit glitch,
                                input string req);
        put_pair(w, ~w);
        if (glitch) begin
            // R7: edges during the write delay
            for (int g = 0; g < 2; g++) begin
                ck_line = 1'b1;
                wait_cyc(4);
                ck_line = 1'b0;
                wait_cyc(4);
            end
        end
        expect_ack(req);
        if (k == 0) exp_img = '0;  // R8 bulk clear
        exp_img[k*W +: W] = w;
        check(req, "image", cfg_image, exp_img);
    endtask

    initial begin
        // R1: reset state
        wait_cyc(5);
        check("R1", "oe in reset", dat_oe, 0);
        check("R1", "err in reset", err_flag, 0);
        check("R1", "image in reset", cfg_image, '0);
        rst = 1'b0;
        wait_cyc(5);

        // R2: setup hold too short
        enter_mode(HOLD - 15);
        put_pair(16'h3C5A, ~16'h3C5A);
        expect_no_ack("R2");
        check("R2", "image", cfg_image, '0);

        // R3: a button input high at entry
        for (int b = 1; b < 3; b++) begin
            btn_in = 2'(b);
            enter_mode(HOLD + 10);
            btn_in = 2'b00;
            put_pair(16'h6699, ~16'h6699);
            expect_no_ack("R3");
            check("R3", "image", cfg_image, '0);
        end

        // R4, R6, R7: valid session, three words
        enter_mode(HOLD + 10);
        program_word(0, 16'hA5C3, 1'b0, "R4");
        lower_ck();
        program_word(1, 16'h1234, 1'b1, "R7");
        lower_ck();
        program_word(2, 16'hFFFF, 1'b0, "R6");
        lower_ck();

        // R5: bad complement
        put_pair(16'h0F00, 16'h0F00);
        expect_no_ack("R5");
        exp_err = 1'b1;
        check("R5", "err", err_flag, exp_err);
        check("R5", "image unchanged", cfg_image, exp_img);

        // R11: no readback after abandoned session
        falls_no_drive("R11");

        // R8: new session, word 0 clears the rest
        enter_mode(HOLD + 10);
        program_word(0, 16'h0F0F, 1'b0, "R8");
        lower_ck();
        for (int k = 1; k < NW; k++) begin
            program_word(k, 16'(k * 16'h1357) ^ 16'h2468, 1'b0, "R6");
            if (k < NW - 1) lower_ck();
        end
        check("R5", "err sticky", err_flag, exp_err);

        // R9: single readback pass
        allow_oe = 1'b1;
        for (int i = 0; i < IMG; i++) begin
            ck_line = 1'b0;
            wait_cyc(6);
            check("R9", "readback enable", dat_oe, 1);
            check("R9", "readback bit", dat_out, exp_img[i]);
            ck_line = 1'b1;
            wait_cyc(6);
        end
        ck_line = 1'b0;
        wait_cyc(6);
        check("R9", "release after last bit", dat_oe, 0);
        allow_oe = 1'b0;
        wait_cyc(6);

        // R10: locked
        enter_mode(HOLD + 10);
        put_pair(16'h5555, ~16'h5555);
        expect_no_ack("R10");
        check("R10", "image frozen", cfg_image, exp_img);
        falls_no_drive("R10");

        // R1: power-on reset clears lock and image
        rst = 1'b1;
        wait_cyc(3);
        rst = 1'b0;
        wait_cyc(2);
        exp_err = 1'b0;
        check("R1", "image after reset", cfg_image, '0);
        check("R1", "err after reset", err_flag, exp_err);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule